// File: doc/BRIEF.md
# Scaled PWM Clock Generator

This block produces the per-channel clock enables for an eight-channel pulse-width modulator. Two base clock enables, A and B, arrive as one-cycle pulses in the system clock domain. Each base enable feeds a prescaler. The prescaler is an 8-bit down counter that emits one pulse for every N base pulses. That pulse drives a divide-by-two toggle. Each rising transition of the toggle becomes a one-cycle scaled enable, so the scaled rate is the base rate divided by 2·N. A scale value of zero counts as 256.

Software writes the two scale registers and an 8-bit clock-select register through write strobes that share one data bus. Writing a scale register reloads its down counter at once with the new value. The clock-select register holds one bit per channel, and that bit picks either the base enable of the channel's group or the scaled enable of that group. Channels whose index has bit 1 clear (0, 1, 4, 5) belong to group A. The others (2, 3, 6, 7) belong to group B. All channel outputs are registered, so a channel pulse appears in the cycle after the base pulse that causes it.

Top module: `pwm_scaled_clkgen`

## Requirements
- R1: After reset, every `chanTick` bit is 0, both scale values and both down counters are 0x00, both toggles are clear, and every select bit is 0.
- R2: A channel whose select bit is 0 pulses `chanTick[i]` in exactly the cycle that follows each base pulse of its group, and at no other time.
- R3: A channel whose select bit is 1, with scale value N from 1 to 255, pulses once every 2·N base pulses of its group. After a reload with the toggle clear, the first pulse follows the N-th base pulse.
- R4: A scale value of 0x00 acts as 256. The first scaled pulse follows the 256th base pulse, and the pulses that follow are 512 base pulses apart.
- R5: A write to a scale register loads its down counter immediately with the written value, without waiting for the old count to run out. A base pulse that arrives in the same cycle as the write is not counted.
- R6: The scaled enable is one system-clock cycle wide and occurs only on the base pulse that sets the toggle. Two scaled pulses of one group are never in adjacent cycles.
- R7: A write to the clock-select register takes effect for base pulses from the next cycle on, and bit i of the written value selects the scaled enable for channel i.
- R8: Group A (channels 0, 1, 4, 5, select mask 0x33) responds only to base A and its prescaler. Group B (channels 2, 3, 6, 7, mask 0xCC) responds only to base B and its prescaler. The two prescalers count independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTickA | input | 1 | One-cycle base enable for group A |
| baseTickB | input | 1 | One-cycle base enable for group B |
| scaleAWr | input | 1 | Write strobe for scale value A |
| scaleBWr | input | 1 | Write strobe for scale value B |
| clkSelWr | input | 1 | Write strobe for the clock-select register |
| wrData | input | 8 | Write data shared by the three strobes |
| chanTick | output | 8 | Per-channel clock-enable pulses |

## Verification
The bench counts base pulses and checks the exact pulse index of each scaled enable.

- **Scale 1:** a design with an off-by-one reload would skip or double a pulse here.
- **Scale 0:** a design that takes zero literally would stall or pulse every cycle instead of waiting 256 and then 512 base pulses.
- **Rewrite mid-count:** a scale register is written again while its counter is counting. A design that lets the old count run out would place the next pulse late.
- **Tick during a write:** a design that also counts this tick would place the next pulse one base pulse early.
- **Mixed selects and isolated groups:** a swapped group mapping shows up as pulses on the wrong channels.

// File: rtl/pwm_sclk_pkg.sv
package pwm_sclk_pkg;
  parameter int SCALE_W = 8;
  parameter int NUM_CH  = 8;
  parameter int NUM_GRP = 2;

  // strobes from the register control to the datapath
  typedef struct packed {
    logic               reloadA;
    logic               reloadB;
    logic [SCALE_W-1:0] reloadVal;
  } sclkStrobes_t;

  // group served by a channel: bit 1 of its index
  function automatic int chanGroup(input int ch);
    return (ch >> 1) & 1;
  endfunction
endpackage

// File: rtl/pwm_sclk_ctrl.sv
module pwm_sclk_ctrl
  import pwm_sclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               scaleAWr,
  input  logic               scaleBWr,
  input  logic               clkSelWr,
  input  logic [SCALE_W-1:0] wrData,
  output logic [SCALE_W-1:0] scaleA,
  output logic [SCALE_W-1:0] scaleB,
  output logic [NUM_CH-1:0]  selReg,
  output sclkStrobes_t       strobes
);
  logic [SCALE_W-1:0] scaleAQ;
  logic [SCALE_W-1:0] scaleBQ;
  logic [NUM_CH-1:0]  selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaleAQ <= '0;
      scaleBQ <= '0;
      selQ    <= '0;
    end else begin
      if (scaleAWr) scaleAQ <= wrData;
      if (scaleBWr) scaleBQ <= wrData;
      if (clkSelWr) selQ    <= wrData[NUM_CH-1:0];
    end
  end

  always_comb begin
    strobes.reloadA   = scaleAWr;
    strobes.reloadB   = scaleBWr;
    strobes.reloadVal = wrData;
  end

  assign scaleA = scaleAQ;
  assign scaleB = scaleBQ;
  assign selReg = selQ;
endmodule

// File: rtl/pwm_sclk_prescaler.sv
module pwm_sclk_prescaler #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               reload,
  input  logic [SCALE_W-1:0] reloadVal,
  input  logic [SCALE_W-1:0] scaleVal,
  output logic [SCALE_W-1:0] cnt,
  output logic               toggle,
  output logic               scaledTick
);
  localparam logic [SCALE_W-1:0] CntLast = SCALE_W'(1);

  logic [SCALE_W-1:0] cntQ;
  logic               toggleQ;
  logic               cntPulse;

  // the counter reaches its last value; a reload in the same cycle wins
  assign cntPulse = tick && !reload && (cntQ == CntLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (reload) begin
      cntQ <= reloadVal;
    end else if (tick) begin
      // a value of zero wraps down through the full range, i.e. 256 counts
      if (cntQ == CntLast) cntQ <= scaleVal;
      else                 cntQ <= cntQ - CntLast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         toggleQ <= 1'b0;
    else if (cntPulse) toggleQ <= ~toggleQ;
  end

  assign scaledTick = cntPulse && !toggleQ;
  assign cnt        = cntQ;
  assign toggle     = toggleQ;
endmodule

// File: rtl/pwm_sclk_datapath.sv
module pwm_sclk_datapath
  import pwm_sclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseTickA,
  input  logic               baseTickB,
  input  logic [SCALE_W-1:0] scaleA,
  input  logic [SCALE_W-1:0] scaleB,
  input  logic [NUM_CH-1:0]  selReg,
  input  sclkStrobes_t       strobes,
  output logic [SCALE_W-1:0] cntA,
  output logic [SCALE_W-1:0] cntB,
  output logic               scaledA,
  output logic               scaledB,
  output logic [NUM_CH-1:0]  chanTick
);
  logic [NUM_GRP-1:0]  baseVec;
  logic [NUM_GRP-1:0]  reloadVec;
  logic [NUM_GRP-1:0]  scaledVec;
  logic [NUM_GRP-1:0]  toggleVec;
  logic [SCALE_W-1:0]  scaleVec [NUM_GRP];
  logic [SCALE_W-1:0]  cntVec   [NUM_GRP];
  logic [NUM_CH-1:0]   chanQ;

  assign baseVec     = {baseTickB, baseTickA};
  assign reloadVec   = {strobes.reloadB, strobes.reloadA};
  assign scaleVec[0] = scaleA;
  assign scaleVec[1] = scaleB;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gPre
    pwm_sclk_prescaler #(.SCALE_W(SCALE_W)) uPre (
      .clk       (clk),
      .rstN      (rstN),
      .tick      (baseVec[g]),
      .reload    (reloadVec[g]),
      .reloadVal (strobes.reloadVal),
      .scaleVal  (scaleVec[g]),
      .cnt       (cntVec[g]),
      .toggle    (toggleVec[g]),
      .scaledTick(scaledVec[g])
    );
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    localparam int Grp = chanGroup(i);
    always_ff @(posedge clk) begin
      if (!rstN) chanQ[i] <= 1'b0;
      else       chanQ[i] <= selReg[i] ? scaledVec[Grp] : baseVec[Grp];
    end
  end

  assign chanTick = chanQ;
  assign cntA     = cntVec[0];
  assign cntB     = cntVec[1];
  assign scaledA  = scaledVec[0];
  assign scaledB  = scaledVec[1];
endmodule

// File: rtl/pwm_scaled_clkgen.sv
module pwm_scaled_clkgen
  import pwm_sclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseTickA,
  input  logic               baseTickB,
  input  logic               scaleAWr,
  input  logic               scaleBWr,
  input  logic               clkSelWr,
  input  logic [SCALE_W-1:0] wrData,
  output logic [NUM_CH-1:0]  chanTick
);
  sclkStrobes_t       strobes;
  logic [SCALE_W-1:0] scaleA;
  logic [SCALE_W-1:0] scaleB;
  logic [NUM_CH-1:0]  selReg;
  logic [SCALE_W-1:0] cntA;
  logic [SCALE_W-1:0] cntB;
  logic               scaledA;
  logic               scaledB;

  pwm_sclk_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .scaleAWr(scaleAWr),
    .scaleBWr(scaleBWr),
    .clkSelWr(clkSelWr),
    .wrData  (wrData),
    .scaleA  (scaleA),
    .scaleB  (scaleB),
    .selReg  (selReg),
    .strobes (strobes)
  );

  pwm_sclk_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .baseTickA(baseTickA),
    .baseTickB(baseTickB),
    .scaleA   (scaleA),
    .scaleB   (scaleB),
    .selReg   (selReg),
    .strobes  (strobes),
    .cntA     (cntA),
    .cntB     (cntB),
    .scaledA  (scaledA),
    .scaledB  (scaledB),
    .chanTick (chanTick)
  );
endmodule

// File: rtl/pwm_sclk_checker.sv
module pwm_sclk_checker
  import pwm_sclk_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               baseTickA,
  input logic               baseTickB,
  input logic               scaleAWr,
  input logic               clkSelWr,
  input logic [SCALE_W-1:0] wrData,
  input logic [SCALE_W-1:0] cntA,
  input logic               scaledA,
  input logic               scaledB,
  input logic [NUM_CH-1:0]  selReg,
  input logic [NUM_CH-1:0]  chanTick
);
  // R1: reset leaves counter, selects and outputs cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (cntA == '0) && (selReg == '0) && (chanTick == '0));

  // R2: a base-selected group A channel follows each base A pulse
  assert_base_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!selReg[0] && baseTickA) |=> chanTick[0]);

  // R8: every channel pulse is caused by a base pulse of its own group
  for (genvar i = 0; i < NUM_CH; i++) begin : gGrp
    if (chanGroup(i) == 0) begin : gA
      assert_group_source_R8: assert property (@(posedge clk) disable iff (!rstN)
        chanTick[i] |-> $past(baseTickA));
    end else begin : gB
      assert_group_source_R8: assert property (@(posedge clk) disable iff (!rstN)
        chanTick[i] |-> $past(baseTickB));
    end
  end

  // R6: scaled pulses of one group are never back to back
  assert_scaled_gap_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    scaledA |=> !scaledA);
  assert_scaled_gap_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    scaledB |=> !scaledB);

  // R5: a scale write loads the down counter at once
  assert_reload_now_R5: assert property (@(posedge clk) disable iff (!rstN)
    scaleAWr |=> cntA == $past(wrData));

  // R5: with no write and no base pulse the counter holds
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!scaleAWr && !baseTickA) |=> $stable(cntA));

  // R7: a select write is visible in the next cycle
  assert_sel_update_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkSelWr |=> selReg == $past(wrData[NUM_CH-1:0]));
endmodule

bind pwm_scaled_clkgen pwm_sclk_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .baseTickA(baseTickA),
  .baseTickB(baseTickB),
  .scaleAWr (scaleAWr),
  .clkSelWr (clkSelWr),
  .wrData   (wrData),
  .cntA     (cntA),
  .scaledA  (scaledA),
  .scaledB  (scaledB),
  .selReg   (selReg),
  .chanTick (chanTick)
);

// File: tb/tb_pwm_scaled_clkgen.sv
module tb_pwm_scaled_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK_A = 8'h33;
  localparam logic [7:0] MASK_B = 8'hCC;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTickA = 1'b0;
  logic       baseTickB = 1'b0;
  logic       scaleAWr = 1'b0;
  logic       scaleBWr = 1'b0;
  logic       clkSelWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] chanTick;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_scaled_clkgen dut (
    .clk(clk), .rstN(rstN), .baseTickA(baseTickA), .baseTickB(baseTickB),
    .scaleAWr(scaleAWr), .scaleBWr(scaleBWr), .clkSelWr(clkSelWr),
    .wrData(wrData), .chanTick(chanTick)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: chanTick=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at the following negedge
  task automatic cyc(input logic a, input logic b);
    baseTickA = a;
    baseTickB = b;
    @(posedge clk);
    @(negedge clk);
    baseTickA = 1'b0;
    baseTickB = 1'b0;
  endtask

  // kind: 0 scale A, 1 scale B, 2 select; optional base A pulse in the same cycle
  task automatic writeReg(input int kind, input logic [7:0] d, input logic withTickA);
    wrData   = d;
    scaleAWr = (kind == 0);
    scaleBWr = (kind == 1);
    clkSelWr = (kind == 2);
    baseTickA = withTickA;
    @(posedge clk);
    @(negedge clk);
    scaleAWr = 1'b0;
    scaleBWr = 1'b0;
    clkSelWr = 1'b0;
    baseTickA = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive numTicks base pulses on one group and compare every sample
  task automatic runScaled(input string req, input bit grpB, input logic [7:0] sel,
                           input int numTicks, input int first, input int period);
    logic [7:0] gm;
    logic [7:0] exp;
    gm = grpB ? MASK_B : MASK_A;
    for (int t = 1; t <= numTicks; t++) begin
      bit hit;
      hit = (t >= first) && (((t - first) % period) == 0);
      exp = (gm & ~sel) | (hit ? (gm & sel) : 8'h00);
      cyc(!grpB, grpB);
      check(req, chanTick, exp);
    end
  endtask

  task automatic testResetState();
    doReset();
    check("R1 reset outputs", chanTick, 8'h00);
    cyc(1'b0, 1'b0);
    check("R1 idle after reset", chanTick, 8'h00);
  endtask

  task automatic testBasePass();
    doReset();
    cyc(1'b1, 1'b0);
    check("R2 R8 base A to group A", chanTick, MASK_A);
    cyc(1'b0, 1'b1);
    check("R2 R8 base B to group B", chanTick, MASK_B);
    cyc(1'b1, 1'b1);
    check("R2 both bases", chanTick, 8'hFF);
    cyc(1'b0, 1'b0);
    check("R2 no base no pulse", chanTick, 8'h00);
  endtask

  task automatic testResetDivide();
    // after reset the counter is 0 and the scale is 0: 256 then every 512
    doReset();
    writeReg(2, 8'hFF, 1'b0);
    runScaled("R1 R4 reset scale", 1'b0, 8'hFF, 800, 256, 512);
  endtask

  task automatic testScaleN(input logic [7:0] n, input int ticks);
    doReset();
    writeReg(2, 8'hFF, 1'b0);
    writeReg(0, n, 1'b0);
    runScaled("R3 R6 scaled period", 1'b0, 8'hFF, ticks, int'(n), 2 * int'(n));
  endtask

  task automatic testScaleZero();
    doReset();
    writeReg(2, 8'hFF, 1'b0);
    writeReg(0, 8'h07, 1'b0);
    writeReg(0, 8'h00, 1'b0);
    runScaled("R4 zero scale", 1'b0, 8'hFF, 800, 256, 512);
  endtask

  task automatic testReloadMid();
    doReset();
    writeReg(2, 8'hFF, 1'b0);
    writeReg(0, 8'd5, 1'b0);
    runScaled("R5 before rewrite", 1'b0, 8'hFF, 2, 99, 1);
    writeReg(0, 8'd2, 1'b0);
    runScaled("R5 reload now", 1'b0, 8'hFF, 6, 2, 4);
  endtask

  task automatic testTickDuringWrite();
    doReset();
    writeReg(2, 8'hFF, 1'b0);
    writeReg(0, 8'd2, 1'b1);
    check("R5 tick with write", chanTick, 8'h00);
    runScaled("R5 tick not counted", 1'b0, 8'hFF, 6, 2, 4);
  endtask

  task automatic testGroupB();
    doReset();
    writeReg(2, 8'hFF, 1'b0);
    writeReg(1, 8'd2, 1'b0);
    runScaled("R8 group B prescaler", 1'b1, 8'hFF, 8, 2, 4);
    // group A prescaler untouched: still at its reset count of 256
    runScaled("R8 group A independent", 1'b0, 8'hFF, 10, 256, 512);
  endtask

  task automatic testMixedSel();
    doReset();
    writeReg(0, 8'd1, 1'b0);
    writeReg(2, 8'h0F, 1'b0);
    cyc(1'b1, 1'b0);
    check("R7 mixed select rise", chanTick, 8'h33);
    cyc(1'b1, 1'b0);
    check("R7 mixed select fall", chanTick, 8'h30);
    writeReg(2, 8'h00, 1'b0);
    cyc(1'b1, 1'b0);
    check("R7 select back to base", chanTick, MASK_A);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    testResetState();
    testBasePass();
    testResetDivide();
    testScaleN(8'd3, 20);
    testScaleN(8'd1, 10);
    testScaleN(8'd255, 1100);
    testScaleZero();
    testReloadMid();
    testTickDuringWrite();
    testGroupB();
    testMixedSel();
    finish();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finish();
    end
  end
endmodule